// File: doc/BRIEF.md
# Transmit/Receive DMA Request Arbiter

This block chooses, cycle by cycle, which of two DMA engines (transmit or receive) may request the host bus. The choice depends on how full the transmit FIFO is, on per-side burst eligibility, on pending work and on a receive-side urgency flag. A programmable 6-bit threshold, counted in 32-byte units, sets the point below which the transmit FIFO is treated as close to underrun. A transmit request in that state skips its burst-size gate and pre-empts receive.

The winner is presented as a registered grant selector, together with a flag telling the bus interface whether the granted burst is urgent. A grant stays in place until the bus interface reports the end of the burst. The block contains no bus protocol, no FIFO storage and no descriptor handling.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset the grant is none (grant = 2'b00), bus_urgent is 0 and the urgent threshold holds 4, so urgency starts below 128 bytes.
- R2: Transmit is urgent when the registered transmit occupancy is less than threshold × 32 bytes. The occupancy register takes one cycle, and urgency clears in the same cycle that the registered occupancy reaches that limit.
- R3: When thr_wr_en is high, thr_wr_data (6 bits) is loaded into the threshold, and it is used from the next cycle onward.
- R4: An urgent transmit request wins over a non-urgent receive request.
- R5: A non-urgent transmit request is raised only when tx_burst_ok is high. An urgent transmit request is raised regardless of tx_burst_ok.
- R6: An urgent receive request (rx_urgent high) wins over a non-urgent transmit request. A receive request needs rx_burst_ok unless rx_urgent is high.
- R7: When both sides request at the same urgency level (both urgent or both not), the grant alternates between them. The first such tie after reset goes to transmit.
- R8: A grant other than none holds until burst_done. In the cycle burst_done is high, the next grant is chosen from the requests present in that cycle.
- R9: bus_urgent is 1 when the granted side was urgent at the decision, and it holds with the grant for the whole burst.
- R10: When no side has a qualified request at a decision, the grant becomes none (2'b00). Grant encodings are 2'b01 for transmit and 2'b10 for receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_occ_bytes | input | OCC_W | Bytes currently held in the transmit FIFO |
| thr_wr_en | input | 1 | Load strobe for the urgent threshold |
| thr_wr_data | input | THR_W | New urgent threshold, in 32-byte units |
| tx_pending | input | 1 | Transmit engine has data to move |
| tx_burst_ok | input | 1 | Transmit burst-size condition met |
| rx_pending | input | 1 | Receive engine has data to move |
| rx_burst_ok | input | 1 | Receive burst-size condition met |
| rx_urgent | input | 1 | Receive side close to overflow |
| burst_done | input | 1 | Bus interface finished the current burst |
| grant | output | 2 | 00 none, 01 transmit, 10 receive |
| bus_urgent | output | 1 | Granted burst is urgent |

## Verification
Request, burst and urgency-flag inputs pass through one register, so a change driven before a rising edge shows on grant and bus_urgent just after that edge. A change in transmit occupancy has to pass the occupancy register first, so its effect on the grant appears one edge later, after two edges in total. The bench drives inputs at the falling edge and samples at the next falling edge. For occupancy and threshold changes it waits one extra edge before raising pending, so every sample falls exactly where the result is due.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [1:0] {
      GNT_NONE = 2'b00,
      GNT_TX   = 2'b01,
      GNT_RX   = 2'b10
   } grant_e;

   localparam int SIDE_TX = 0;
   localparam int SIDE_RX = 1;
   localparam int NUM_SIDES = 2;
endpackage

// File: rtl/tx_urgency_detect.sv
module tx_urgency_detect #(
   parameter int OCC_W     = 12,
   parameter int THR_W     = 6,
   parameter int UNIT_LOG2 = 5,
   parameter int THR_RESET = 4,
   parameter bit REG_OCC   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] occ_bytes,
   input  logic             thr_wr_en,
   input  logic [THR_W-1:0] thr_wr_data,
   output logic             tx_urgent
);
   localparam int LIM_W = THR_W + UNIT_LOG2;
   localparam int CMP_W = (OCC_W > LIM_W) ? OCC_W : LIM_W;

   generate
      if (OCC_W < 1 || THR_W < 1 || UNIT_LOG2 < 0)
         $error("tx_urgency_detect: bad width parameters");
      if (THR_RESET < 0 || THR_RESET >= (1 << THR_W))
         $error("tx_urgency_detect: THR_RESET does not fit THR_W");
   endgenerate

   logic [THR_W-1:0] thr_q;
   logic [OCC_W-1:0] occ_used;
   logic [CMP_W-1:0] limit;
   logic [CMP_W-1:0] occ_ext;

   always_ff @(posedge clk) begin
      if (!rst_n)         thr_q <= THR_W'(THR_RESET);
      else if (thr_wr_en) thr_q <= thr_wr_data;
   end

   generate
      if (REG_OCC) begin : g_reg_occ
         logic [OCC_W-1:0] occ_q;
         always_ff @(posedge clk) begin
            if (!rst_n) occ_q <= '1;
            else        occ_q <= occ_bytes;
         end
         assign occ_used = occ_q;

         assert_urgent_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (CMP_W'(occ_bytes) < limit && !thr_wr_en) |=> tx_urgent);
         assert_urgent_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (CMP_W'(occ_bytes) >= limit && !thr_wr_en) |=> !tx_urgent);
      end else begin : g_comb_occ
         assign occ_used = occ_bytes;
      end
   endgenerate

   assign limit     = CMP_W'(thr_q) << UNIT_LOG2;
   assign occ_ext   = CMP_W'(occ_used);
   assign tx_urgent = (occ_ext < limit);
endmodule

// File: rtl/req_qualify.sv
module req_qualify
   import dma_arb_pkg::*;
(
   input  logic [NUM_SIDES-1:0] pending,
   input  logic [NUM_SIDES-1:0] burst_ok,
   input  logic [NUM_SIDES-1:0] urgent,
   output logic [NUM_SIDES-1:0] req,
   output logic [NUM_SIDES-1:0] urg_req
);
   generate
      for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
         assign req[s]     = pending[s] & (burst_ok[s] | urgent[s]);
         assign urg_req[s] = pending[s] & urgent[s];
      end
   endgenerate
endmodule

// File: rtl/grant_select.sv
module grant_select
   import dma_arb_pkg::*;
#(
   parameter bit TIE_START_TX = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SIDES-1:0] req,
   input  logic [NUM_SIDES-1:0] urg_req,
   input  logic                 burst_done,
   output grant_e               grant,
   output logic                 urgent_out
);
   grant_e grant_q, pick;
   logic   urg_q, last_tx_q, decide, any_urg;
   logic [NUM_SIDES-1:0] cand;

   assign decide  = (grant_q == GNT_NONE) || burst_done;
   assign any_urg = |urg_req;
   assign cand    = any_urg ? urg_req : req;

   always_comb begin
      unique case (cand)
         2'b01:   pick = GNT_TX;
         2'b10:   pick = GNT_RX;
         2'b11:   pick = last_tx_q ? GNT_RX : GNT_TX;
         default: pick = GNT_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_q   <= GNT_NONE;
         urg_q     <= 1'b0;
         last_tx_q <= !TIE_START_TX;
      end else if (decide) begin
         grant_q <= pick;
         urg_q   <= (pick != GNT_NONE) && any_urg;
         if (pick == GNT_TX)      last_tx_q <= 1'b1;
         else if (pick == GNT_RX) last_tx_q <= 1'b0;
      end
   end

   assign grant      = grant_q;
   assign urgent_out = urg_q;

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (grant != GNT_NONE && !burst_done) |=> (grant == $past(grant) && urgent_out == $past(urgent_out)));
   assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && req == '0) |=> (grant == GNT_NONE && !urgent_out));
   assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && cand == 2'b11 && last_tx_q) |=> grant == GNT_RX);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dma_arb_pkg::*;
#(
   parameter int OCC_W        = 12,
   parameter int THR_W        = 6,
   parameter int UNIT_LOG2    = 5,
   parameter int THR_RESET    = 4,
   parameter bit REG_OCC      = 1'b1,
   parameter bit TIE_START_TX = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [OCC_W-1:0] tx_occ_bytes,
   input  logic             thr_wr_en,
   input  logic [THR_W-1:0] thr_wr_data,
   input  logic             tx_pending,
   input  logic             tx_burst_ok,
   input  logic             rx_pending,
   input  logic             rx_burst_ok,
   input  logic             rx_urgent,
   input  logic             burst_done,
   output logic [1:0]       grant,
   output logic             bus_urgent
);
   logic                 tx_urgent;
   logic [NUM_SIDES-1:0] req, urg_req;
   grant_e               grant_e_w;
   logic                 decide;

   tx_urgency_detect #(
      .OCC_W(OCC_W), .THR_W(THR_W), .UNIT_LOG2(UNIT_LOG2),
      .THR_RESET(THR_RESET), .REG_OCC(REG_OCC)
   ) i_urg (
      .clk(clk), .rst_n(rst_n), .occ_bytes(tx_occ_bytes),
      .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data), .tx_urgent(tx_urgent)
   );

   req_qualify i_qual (
      .pending ({rx_pending,  tx_pending}),
      .burst_ok({rx_burst_ok, tx_burst_ok}),
      .urgent  ({rx_urgent,   tx_urgent}),
      .req     (req),
      .urg_req (urg_req)
   );

   grant_select #(.TIE_START_TX(TIE_START_TX)) i_sel (
      .clk(clk), .rst_n(rst_n), .req(req), .urg_req(urg_req),
      .burst_done(burst_done), .grant(grant_e_w), .urgent_out(bus_urgent)
   );

   assign grant  = grant_e_w;
   assign decide = (grant == GNT_NONE) || burst_done;

   assert_tx_preempt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && tx_pending && tx_urgent && !(rx_pending && rx_urgent)) |=> (grant == GNT_TX && bus_urgent));
   assert_burst_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && !tx_burst_ok && !tx_urgent) |=> grant != GNT_TX);
   assert_rx_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (decide && rx_pending && rx_urgent && !(tx_pending && tx_urgent)) |=> grant == GNT_RX);
endmodule

// File: tb/test_dma_req_arbiter.sv
module test_dma_req_arbiter;
   localparam int CLK_PERIOD = 10;
   localparam int OCC_W = 12;
   localparam int THR_W = 6;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [OCC_W-1:0] tx_occ_bytes;
   logic             thr_wr_en;
   logic [THR_W-1:0] thr_wr_data;
   logic             tx_pending, tx_burst_ok, rx_pending, rx_burst_ok, rx_urgent, burst_done;
   logic [1:0]       grant;
   logic             bus_urgent;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_req_arbiter i_dma_req_arbiter (
      .clk(clk), .rst_n(rst_n), .tx_occ_bytes(tx_occ_bytes),
      .thr_wr_en(thr_wr_en), .thr_wr_data(thr_wr_data),
      .tx_pending(tx_pending), .tx_burst_ok(tx_burst_ok),
      .rx_pending(rx_pending), .rx_burst_ok(rx_burst_ok), .rx_urgent(rx_urgent),
      .burst_done(burst_done), .grant(grant), .bus_urgent(bus_urgent)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic expect_out(input logic [1:0] g, input logic u, input string tag);
      checks++;
      if (grant !== g || bus_urgent !== u) begin
         errors++;
         $display("FAIL %s: grant=%b urgent=%b expected grant=%b urgent=%b", tag, grant, bus_urgent, g, u);
      end
   endtask

   task automatic quiet();
      tx_pending = 0; tx_burst_ok = 0; rx_pending = 0; rx_burst_ok = 0; rx_urgent = 0;
   endtask

   task automatic release_bus();
      quiet();
      burst_done = 1; step(); burst_done = 0;
   endtask

   task automatic t_reset();
      expect_out(2'b00, 1'b0, "R1 reset grant");
   endtask

   task automatic t_default_thr();
      tx_occ_bytes = 127; step();
      tx_pending = 1; step();
      expect_out(2'b01, 1'b1, "R1 R2 below default limit");
      release_bus();
      tx_occ_bytes = 128; step();
      tx_pending = 1; step();
      expect_out(2'b00, 1'b0, "R2 at limit not urgent");
      quiet(); step();
   endtask

   task automatic t_thr_write();
      thr_wr_en = 1; thr_wr_data = 8; step(); thr_wr_en = 0;
      tx_occ_bytes = 200; step();
      tx_pending = 1; step();
      expect_out(2'b01, 1'b1, "R3 new limit 256 urgent");
      release_bus();
      tx_occ_bytes = 256; step();
      tx_pending = 1; step();
      expect_out(2'b00, 1'b0, "R3 new limit reached");
      quiet();
      thr_wr_en = 1; thr_wr_data = 4; step(); thr_wr_en = 0;
      tx_occ_bytes = 1000; step();
   endtask

   task automatic t_burst_gate();
      tx_pending = 1; tx_burst_ok = 1; step();
      expect_out(2'b01, 1'b0, "R5 non-urgent tx with burst ok");
      release_bus();
   endtask

   task automatic t_tx_preempt();
      tx_occ_bytes = 50; step();
      tx_pending = 1; rx_pending = 1; rx_burst_ok = 1; step();
      expect_out(2'b01, 1'b1, "R4 urgent tx beats rx");
      release_bus();
      tx_pending = 1; rx_pending = 1; rx_urgent = 1; step();
      expect_out(2'b10, 1'b1, "R7 R9 both urgent alternates to rx");
      release_bus();
      tx_occ_bytes = 1000; step();
   endtask

   task automatic t_rx_preempt();
      tx_pending = 1; tx_burst_ok = 1; rx_pending = 1; rx_urgent = 1; step();
      expect_out(2'b10, 1'b1, "R6 urgent rx beats tx without rx burst ok");
      release_bus();
   endtask

   task automatic t_round_robin();
      tx_pending = 1; tx_burst_ok = 1; rx_pending = 1; rx_burst_ok = 1; step();
      expect_out(2'b01, 1'b0, "R7 tie after rx goes tx");
      release_bus();
      tx_pending = 1; tx_burst_ok = 1; rx_pending = 1; rx_burst_ok = 1; step();
      expect_out(2'b10, 1'b0, "R7 tie after tx goes rx");
      release_bus();
   endtask

   task automatic t_hold();
      tx_pending = 1; tx_burst_ok = 1; step();
      expect_out(2'b01, 1'b0, "R8 grant tx");
      quiet(); rx_pending = 1; rx_burst_ok = 1;
      for (int i = 0; i < 3; i++) begin
         step();
         expect_out(2'b01, 1'b0, "R8 held without burst_done");
      end
      burst_done = 1; step(); burst_done = 0;
      expect_out(2'b10, 1'b0, "R8 handover on burst_done");
      release_bus();
   endtask

   task automatic t_idle();
      tx_burst_ok = 1; rx_burst_ok = 1; step();
      expect_out(2'b00, 1'b0, "R10 no pending no grant");
      quiet(); rx_pending = 1; step();
      expect_out(2'b00, 1'b0, "R6 R10 rx without burst ok or urgent");
      quiet(); step();
   endtask

   task automatic t_urgent_held();
      tx_occ_bytes = 50; step();
      tx_pending = 1; step();
      expect_out(2'b01, 1'b1, "R9 urgent grant");
      tx_occ_bytes = 1000; step(); step();
      expect_out(2'b01, 1'b1, "R9 urgent held after occupancy recovers");
      release_bus();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; tx_occ_bytes = 1000; thr_wr_en = 0; thr_wr_data = '0; burst_done = 0;
      quiet();
      repeat (3) step();
      rst_n = 1; step();
      t_reset();
      t_default_thr();
      t_thr_write();
      t_burst_gate();
      t_tx_preempt();
      t_rx_preempt();
      t_round_robin();
      t_hold();
      t_idle();
      t_urgent_held();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule